// File: doc/BRIEF.md
# Batched Sector Erase Scheduler

This controller collects sector erase requests into one batch and then hands the sectors one at a time to an external erase engine. A decoded erase confirm opens a short acceptance window. Each further confirm that arrives inside the window adds its sector to the batch and restarts the window count. When the window runs out without interruption, the batch is locked and erasing begins. The controller works in microseconds, counted on a one-cycle `us_tick` strobe, so every duration below is a number of tick pulses.

Sectors flagged in the protect mask are skipped. A batch that holds only protected sectors keeps the block busy for a fixed hold time and then ends without erasing anything. An erase can be suspended and resumed. A suspend inside the window takes effect at once. A suspend during erasing aborts the engine and settles after a fixed latency. A suspend that comes too soon after a resume is held back until the minimum gap has passed. The controller counts suspends in each batch and raises a flag once their number passes a limit.

Top module: `erase_batch_sched`

## Requirements
- R1: After a synchronous reset, `busy`, `suspended`, `window_open`, `erase_phase`, `overuse`, `eng_start`, `eng_abort` and the whole `pending` bitmap are 0.
- R2: In idle, a `cmd_sec_erase` with `cmd_sector` below NUM_SECTORS sets bit `cmd_sector` of `pending` (bit i stands for sector i) and opens the window: `window_open`=1, `busy`=1, `erase_phase`=0. A confirm with an out-of-range index is ignored.
- R3: Each valid confirm inside the window adds its sector and restarts the count. The window closes on the WINDOW_US-th tick after the latest confirm.
- R4: Any other command, chip erase or resume received inside the window aborts the batch: `pending` goes to 0, `busy` goes to 0, and no sector is started.
- R5: When the window closes, `window_open` drops and `erase_phase` becomes 1. A sector confirm received after that leaves `pending` unchanged.
- R6: Sectors are erased one at a time in ascending index order. Each start pulses `eng_start` with the sector on `eng_sector`. Protected sectors are never started. A sector's `pending` bit clears on `eng_done`, and the block returns to idle with `pending`=0 once no unprotected sector remains.
- R7: If no requested sector can be erased because all are protected, `busy` stays 1 for PROT_HOLD_US ticks after the window closes, then the block returns to idle with `pending`=0 and without any `eng_start`.
- R8: A suspend inside the window sets `suspended` on the next clock, with `window_open`=0 and `busy`=0.
- R9: A suspend during erasing pulses `eng_abort`, and `suspended` rises on the SUSP_LAT_US-th tick after that.
- R10: Resume acts only while suspended. It clears `suspended` and restarts the interrupted sector (the lowest pending unprotected one). A resume while erasing is ignored.
- R11: A suspend that arrives fewer than RESUME_GAP_US ticks after a resume is held. It takes effect only once RESUME_GAP_US ticks have passed since the resume.
- R12: While suspended, sector erase and chip erase requests are refused and `pending` is unchanged.
- R13: `overuse` becomes 1 once more than SUSP_LIMIT suspends have occurred in one batch. It stays 1 until the batch ends and reads 0 in the next idle state.
- R14: In idle, `cmd_chip_erase` sets every `pending` bit and starts erasing without opening a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle strobe per microsecond |
| cmd_sec_erase | input | 1 | Sector erase confirm strobe |
| cmd_sector | input | $clog2(NUM_SECTORS) | Sector index of the confirm |
| cmd_chip_erase | input | 1 | Whole-device erase request strobe |
| cmd_suspend | input | 1 | Suspend strobe |
| cmd_resume | input | 1 | Resume strobe |
| cmd_other | input | 1 | Any other decoded command |
| prot_mask | input | NUM_SECTORS | Bit i set means sector i is protected |
| eng_done | input | 1 | Engine finished the current sector |
| pending | output | NUM_SECTORS | Sectors still queued in the batch |
| busy | output | 1 | Window, erase, suspend latency or protect hold in progress |
| suspended | output | 1 | Erase is suspended |
| window_open | output | 1 | Acceptance window open |
| erase_phase | output | 1 | 0 while the window is open, 1 once erasing has begun |
| overuse | output | 1 | Suspend count limit exceeded in this batch |
| eng_start | output | 1 | Start pulse to the engine |
| eng_sector | output | $clog2(NUM_SECTORS) | Sector for the engine |
| eng_abort | output | 1 | Abort pulse to the engine |

## Verification
The bench builds the block with the full 19-sector map and the real window, latency, gap and hold lengths, but lowers SUSP_LIMIT to 3, so that the overuse flag is reached in four suspend cycles. A model engine takes 450 ticks per sector, which is longer than the resume gap, so a held suspend can be observed before the sector would finish. Under these values the bench runs a single-sector batch for each of the 19 indices and a chip erase across the whole map. It also checks each timing boundary one tick before and at the tick where the change is due.

// File: rtl/esched_pkg.sv
package esched_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WINDOW,
        ST_SELECT,
        ST_RUN,
        ST_SUSP_WAIT,
        ST_SUSPENDED,
        ST_PROT_HOLD
    } esched_state_e;

    typedef struct packed {
        logic busy;
        logic suspended;
        logic window_open;
        logic erase_phase;
    } esched_flags_t;

    function automatic esched_flags_t flags_of(esched_state_e s);
        esched_flags_t f;
        f = '0;
        case (s)
            ST_WINDOW:    f.window_open = 1'b1;
            ST_SUSPENDED: f.suspended   = 1'b1;
            default: ;
        endcase
        f.busy = (s == ST_WINDOW) || (s == ST_SELECT) || (s == ST_RUN) ||
                 (s == ST_SUSP_WAIT) || (s == ST_PROT_HOLD);
        f.erase_phase = (s == ST_SELECT) || (s == ST_RUN) || (s == ST_SUSP_WAIT) ||
                        (s == ST_SUSPENDED) || (s == ST_PROT_HOLD);
        return f;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/esched_us_timer.sv
module esched_us_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] target,
    output logic         hit
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick && (cnt < target)) begin
            cnt <= cnt + W'(1);
        end
    end

    assign hit = tick && (cnt == (target - W'(1)));

    // R3: the count never passes the target it is measuring
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && $past(target) == target) |-> cnt <= target);

endmodule

// File: rtl/esched_pick.sv
module esched_pick #(
    parameter int N  = 19,
    parameter int IW = 5
) (
    input  logic [N-1:0]  avail,
    output logic          valid,
    output logic [IW-1:0] idx
);
    logic [N:0]   none_below;
    logic [N-1:0] sel;

    assign none_below[0] = 1'b1;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign sel[i]          = avail[i] & none_below[i];
        assign none_below[i+1] = none_below[i] & ~avail[i];
    end

    assign valid = ~none_below[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) idx = IW'(i);
        end
    end

    // R6: at most one sector chosen, and a choice exists exactly when one is available
    always_comb begin
        assert_sel_onehot_R6: assert ($onehot0(sel));
        assert_sel_valid_R6: assert (valid == (avail != '0));
    end

endmodule

// File: rtl/erase_batch_sched.sv
module erase_batch_sched
    import esched_pkg::*;
#(
    parameter int NUM_SECTORS   = 19,
    parameter int WINDOW_US     = 40,
    parameter int SUSP_LAT_US   = 20,
    parameter int RESUME_GAP_US = 400,
    parameter int PROT_HOLD_US  = 100,
    parameter int SUSP_LIMIT    = 1024,
    localparam int IDX_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   us_tick,
    input  logic                   cmd_sec_erase,
    input  logic [IDX_W-1:0]       cmd_sector,
    input  logic                   cmd_chip_erase,
    input  logic                   cmd_suspend,
    input  logic                   cmd_resume,
    input  logic                   cmd_other,
    input  logic [NUM_SECTORS-1:0] prot_mask,
    input  logic                   eng_done,
    output logic [NUM_SECTORS-1:0] pending,
    output logic                   busy,
    output logic                   suspended,
    output logic                   window_open,
    output logic                   erase_phase,
    output logic                   overuse,
    output logic                   eng_start,
    output logic [IDX_W-1:0]       eng_sector,
    output logic                   eng_abort
);
    localparam int unsigned PH_MAX = max2(max2(WINDOW_US, SUSP_LAT_US), PROT_HOLD_US);
    localparam int TMR_W = $clog2(PH_MAX + 1);
    localparam int GAP_W = $clog2(RESUME_GAP_US + 1);
    localparam int SC_W  = $clog2(SUSP_LIMIT + 2);
    localparam logic [SC_W-1:0] SC_MAX = SC_W'(SUSP_LIMIT + 1);
    localparam logic [NUM_SECTORS-1:0] ONE = NUM_SECTORS'(1);

    esched_state_e st, st_d;
    logic [NUM_SECTORS-1:0] pend_d;
    logic [IDX_W-1:0]       cur_d;
    logic                   erased_any, erased_any_d;
    logic                   susp_req, susp_req_d;
    logic                   resumed_once, resumed_once_d;
    logic                   gap_done, gap_done_d;
    logic [SC_W-1:0]        susp_cnt, susp_cnt_d;
    logic                   start_d, abort_d;
    logic                   restart, gap_clr;

    logic                   sec_ok;
    logic [NUM_SECTORS-1:0] req_bit;
    logic                   pick_valid;
    logic [IDX_W-1:0]       pick_idx;
    logic [TMR_W-1:0]       ph_target;
    logic                   ph_hit, ph_clr, gap_hit, gap_ok, want_susp;
    esched_flags_t          flg;

    assign sec_ok  = (32'(cmd_sector) < NUM_SECTORS);
    assign req_bit = sec_ok ? (ONE << cmd_sector) : '0;
    assign gap_ok  = !resumed_once || gap_done;
    assign want_susp = susp_req || cmd_suspend;

    esched_pick #(.N(NUM_SECTORS), .IW(IDX_W)) u_pick (
        .avail (pending & ~prot_mask),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    always_comb begin
        case (st)
            ST_WINDOW:    ph_target = TMR_W'(WINDOW_US);
            ST_SUSP_WAIT: ph_target = TMR_W'(SUSP_LAT_US);
            default:      ph_target = TMR_W'(PROT_HOLD_US);
        endcase
    end

    esched_us_timer #(.W(TMR_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .clr    (ph_clr),
        .tick   (us_tick),
        .target (ph_target),
        .hit    (ph_hit)
    );

    esched_us_timer #(.W(GAP_W)) u_gap (
        .clk    (clk),
        .rst    (rst),
        .clr    (gap_clr),
        .tick   (us_tick),
        .target (GAP_W'(RESUME_GAP_US)),
        .hit    (gap_hit)
    );

    always_comb begin
        st_d           = st;
        pend_d         = pending;
        cur_d          = eng_sector;
        erased_any_d   = erased_any;
        susp_req_d     = susp_req;
        resumed_once_d = resumed_once;
        gap_done_d     = gap_done || gap_hit;
        susp_cnt_d     = susp_cnt;
        start_d        = 1'b0;
        abort_d        = 1'b0;
        restart        = 1'b0;
        gap_clr        = 1'b0;
        case (st)
            ST_IDLE: begin
                erased_any_d   = 1'b0;
                susp_req_d     = 1'b0;
                resumed_once_d = 1'b0;
                susp_cnt_d     = '0;
                if (cmd_chip_erase) begin
                    pend_d = '1;
                    st_d   = ST_SELECT;
                end else if (cmd_sec_erase && sec_ok) begin
                    pend_d = req_bit;
                    st_d   = ST_WINDOW;
                end
            end
            ST_WINDOW: begin
                if (cmd_suspend) begin
                    st_d = ST_SUSPENDED;
                    if (susp_cnt != SC_MAX) susp_cnt_d = susp_cnt + SC_W'(1);
                end else if (cmd_sec_erase && sec_ok) begin
                    pend_d  = pending | req_bit;
                    restart = 1'b1;
                end else if (cmd_other || cmd_chip_erase || cmd_resume) begin
                    pend_d = '0;
                    st_d   = ST_IDLE;
                end else if (ph_hit) begin
                    st_d = ST_SELECT;
                end
            end
            ST_SELECT: begin
                if (cmd_suspend) susp_req_d = 1'b1;
                if (pick_valid) begin
                    start_d = 1'b1;
                    cur_d   = pick_idx;
                    st_d    = ST_RUN;
                end else if (!erased_any) begin
                    st_d = ST_PROT_HOLD;
                end else begin
                    pend_d = '0;
                    st_d   = ST_IDLE;
                end
            end
            ST_RUN: begin
                if (want_susp && gap_ok) begin
                    abort_d    = 1'b1;
                    susp_req_d = 1'b0;
                    st_d       = ST_SUSP_WAIT;
                end else begin
                    if (cmd_suspend) susp_req_d = 1'b1;
                    if (eng_done) begin
                        pend_d       = pending & ~(ONE << eng_sector);
                        erased_any_d = 1'b1;
                        st_d         = ST_SELECT;
                    end
                end
            end
            ST_SUSP_WAIT: begin
                if (ph_hit) begin
                    st_d = ST_SUSPENDED;
                    if (susp_cnt != SC_MAX) susp_cnt_d = susp_cnt + SC_W'(1);
                end
            end
            ST_SUSPENDED: begin
                if (cmd_resume) begin
                    resumed_once_d = 1'b1;
                    gap_done_d     = 1'b0;
                    gap_clr        = 1'b1;
                    st_d           = ST_SELECT;
                end
            end
            ST_PROT_HOLD: begin
                if (ph_hit) begin
                    pend_d = '0;
                    st_d   = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign ph_clr = (st_d != st) || restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            pending      <= '0;
            eng_sector   <= '0;
            erased_any   <= 1'b0;
            susp_req     <= 1'b0;
            resumed_once <= 1'b0;
            gap_done     <= 1'b0;
            susp_cnt     <= '0;
            eng_start    <= 1'b0;
            eng_abort    <= 1'b0;
        end else begin
            st           <= st_d;
            pending      <= pend_d;
            eng_sector   <= cur_d;
            erased_any   <= erased_any_d;
            susp_req     <= susp_req_d;
            resumed_once <= resumed_once_d;
            gap_done     <= gap_done_d;
            susp_cnt     <= susp_cnt_d;
            eng_start    <= start_d;
            eng_abort    <= abort_d;
        end
    end

    assign flg         = flags_of(st);
    assign busy        = flg.busy;
    assign suspended   = flg.suspended;
    assign window_open = flg.window_open;
    assign erase_phase = flg.erase_phase;
    assign overuse     = (susp_cnt > SC_W'(SUSP_LIMIT));

    // R6: the engine is only started on a queued, unprotected sector
    assert_start_unprot_R6: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> (pending[eng_sector] && !prot_mask[eng_sector]));

    // R12: outside idle and the window no sector is ever added
    assert_no_growth_R12: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && st != ST_WINDOW) |=> ((pending & ~$past(pending)) == '0));

    // R10: leaving the suspended state needs a resume
    assert_resume_exit_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(suspended) |-> $past(cmd_resume));

    // R13: the overuse flag holds until the batch has ended
    assert_overuse_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (overuse && st != ST_IDLE) |=> overuse);

    // R9: an abort pulse leaves the block busy and not yet suspended
    assert_abort_latency_R9: assert property (@(posedge clk) disable iff (rst)
        eng_abort |-> (busy && !suspended));

endmodule

// File: tb/tb_erase_batch_sched.sv
module tb_erase_batch_sched;
    localparam int NS = 19;
    localparam int IW = 5;
    localparam int ENG_US = 450;
    localparam int LIM = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic us_tick = 1'b0;
    logic cmd_sec_erase = 1'b0, cmd_chip_erase = 1'b0, cmd_suspend = 1'b0;
    logic cmd_resume = 1'b0, cmd_other = 1'b0;
    logic [IW-1:0] cmd_sector = '0;
    logic [NS-1:0] prot_mask = '0;
    logic eng_done;
    logic [NS-1:0] pending;
    logic busy, suspended, window_open, erase_phase, overuse, eng_start, eng_abort;
    logic [IW-1:0] eng_sector;

    int errors = 0;
    int checks = 0;
    int start_cnt = 0, done_cnt = 0, abort_cnt = 0;
    int start_log [64];

    always #2 clk = ~clk;

    erase_batch_sched #(.NUM_SECTORS(NS), .SUSP_LIMIT(LIM)) dut (
        .clk(clk), .rst(rst), .us_tick(us_tick),
        .cmd_sec_erase(cmd_sec_erase), .cmd_sector(cmd_sector),
        .cmd_chip_erase(cmd_chip_erase), .cmd_suspend(cmd_suspend),
        .cmd_resume(cmd_resume), .cmd_other(cmd_other),
        .prot_mask(prot_mask), .eng_done(eng_done),
        .pending(pending), .busy(busy), .suspended(suspended),
        .window_open(window_open), .erase_phase(erase_phase),
        .overuse(overuse), .eng_start(eng_start), .eng_sector(eng_sector),
        .eng_abort(eng_abort)
    );

    // model erase engine
    logic e_busy;
    int   e_cnt;
    always @(posedge clk) begin
        if (rst) begin
            eng_done <= 1'b0;
            e_busy   <= 1'b0;
            e_cnt    <= 0;
        end else begin
            eng_done <= 1'b0;
            if (eng_abort) begin
                e_busy    <= 1'b0;
                abort_cnt <= abort_cnt + 1;
            end else if (eng_start) begin
                e_busy <= 1'b1;
                e_cnt  <= 0;
                start_log[start_cnt % 64] <= int'(eng_sector);
                start_cnt <= start_cnt + 1;
            end else if (e_busy && us_tick) begin
                if (e_cnt == ENG_US - 1) begin
                    eng_done <= 1'b1;
                    e_busy   <= 1'b0;
                    done_cnt <= done_cnt + 1;
                end else begin
                    e_cnt <= e_cnt + 1;
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic confirm(input int s);
        cmd_sector = IW'(s);
        cmd_sec_erase = 1'b1;
        @(negedge clk);
        cmd_sec_erase = 1'b0;
    endtask

    task automatic pulse_chip();
        cmd_chip_erase = 1'b1; @(negedge clk); cmd_chip_erase = 1'b0;
    endtask
    task automatic pulse_susp();
        cmd_suspend = 1'b1; @(negedge clk); cmd_suspend = 1'b0;
    endtask
    task automatic pulse_resume();
        cmd_resume = 1'b1; @(negedge clk); cmd_resume = 1'b0;
    endtask
    task automatic pulse_other();
        cmd_other = 1'b1; @(negedge clk); cmd_other = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 20000 && (busy || suspended); k++) ticks(1);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int s0, d0, a0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 suspended", suspended, 0);
        check("R1 window_open", window_open, 0);
        check("R1 erase_phase", erase_phase, 0);
        check("R1 overuse", overuse, 0);
        check("R1 pending", int'(pending), 0);

        // R2 out-of-range index ignored
        confirm(25);
        check("R2 bad index busy", busy, 0);
        check("R2 bad index pending", int'(pending), 0);

        // R2 R3 R5 window timing
        s0 = start_cnt;
        confirm(4);
        check("R2 pending", int'(pending), 1 << 4);
        check("R2 window_open", window_open, 1);
        check("R2 erase_phase", erase_phase, 0);
        ticks(39);
        check("R3 open before expiry", window_open, 1);
        confirm(7);
        check("R3 added", int'(pending), (1 << 4) | (1 << 7));
        ticks(39);
        check("R3 restart still open", window_open, 1);
        ticks(1);
        check("R5 closed", window_open, 0);
        check("R5 erase_phase", erase_phase, 1);
        confirm(9);
        check("R5 rejected", int'(pending), (1 << 4) | (1 << 7));
        wait_idle();
        check("R6 two starts", start_cnt - s0, 2);
        check("R6 first sector", start_log[s0 % 64], 4);
        check("R6 second sector", start_log[(s0 + 1) % 64], 7);
        check("R6 pending cleared", int'(pending), 0);

        // R4 abort
        s0 = start_cnt;
        confirm(3);
        ticks(5);
        pulse_other();
        check("R4 pending", int'(pending), 0);
        check("R4 busy", busy, 0);
        ticks(60);
        check("R4 no start", start_cnt - s0, 0);

        // R6 protected skipping with order
        prot_mask = (NS'(1) << 3) | (NS'(1) << 12);
        s0 = start_cnt;
        confirm(10); confirm(3); confirm(15); confirm(0); confirm(12);
        ticks(40);
        wait_idle();
        check("R6 prot starts", start_cnt - s0, 3);
        check("R6 prot order0", start_log[s0 % 64], 0);
        check("R6 prot order1", start_log[(s0 + 1) % 64], 10);
        check("R6 prot order2", start_log[(s0 + 2) % 64], 15);
        check("R6 prot pending", int'(pending), 0);

        // R6 sweep over every sector
        prot_mask = '0;
        for (int s = 0; s < NS; s++) begin
            d0 = done_cnt;
            confirm(s);
            ticks(40);
            wait_idle();
            check("R6 sweep sector", start_log[(start_cnt - 1) % 64], s);
            check("R6 sweep done", done_cnt - d0, 1);
            check("R6 sweep idle", busy, 0);
        end

        // R7 all protected
        prot_mask = '1;
        s0 = start_cnt;
        confirm(5);
        ticks(40);
        check("R7 erase_phase", erase_phase, 1);
        ticks(99);
        check("R7 busy hold", busy, 1);
        ticks(1);
        check("R7 idle", busy, 0);
        check("R7 pending", int'(pending), 0);
        check("R7 no start", start_cnt - s0, 0);

        // R14 chip erase
        prot_mask = (NS'(1) << 0) | (NS'(1) << 18);
        s0 = start_cnt;
        pulse_chip();
        check("R14 pending all", int'(pending), (1 << NS) - 1);
        check("R14 no window", window_open, 0);
        check("R14 busy", busy, 1);
        wait_idle();
        check("R14 starts", start_cnt - s0, NS - 2);
        check("R14 first", start_log[s0 % 64], 1);
        check("R14 last", start_log[(start_cnt - 1) % 64], NS - 2);

        // R8 .. R13 suspend and resume
        prot_mask = '0;
        confirm(6);
        ticks(2);
        pulse_susp();
        check("R8 suspended", suspended, 1);
        check("R8 window closed", window_open, 0);
        pulse_chip();
        confirm(9);
        check("R12 refused", int'(pending), 1 << 6);
        check("R12 still suspended", suspended, 1);
        s0 = start_cnt;
        pulse_resume();
        check("R10 resumed", suspended, 0);
        ticks(1);
        check("R10 restart sector", start_log[(start_cnt - 1) % 64], 6);
        check("R10 one start", start_cnt - s0, 1);
        a0 = abort_cnt;
        pulse_resume();
        check("R10 resume ignored", suspended, 0);
        check("R10 still busy", busy, 1);
        ticks(9);
        pulse_susp();
        ticks(389);
        check("R11 held suspend", suspended, 0);
        check("R11 no abort yet", abort_cnt - a0, 0);
        ticks(1);
        ticks(19);
        check("R9 not yet suspended", suspended, 0);
        check("R9 abort sent", abort_cnt - a0, 1);
        ticks(1);
        check("R9 suspended", suspended, 1);
        check("R13 below limit", overuse, 0);
        pulse_resume();
        ticks(400);
        pulse_susp();
        ticks(19);
        check("R9 latency again", suspended, 0);
        ticks(1);
        check("R9 suspended again", suspended, 1);
        check("R13 at limit", overuse, 0);
        pulse_resume();
        ticks(400);
        pulse_susp();
        ticks(20);
        check("R13 over limit", overuse, 1);
        d0 = done_cnt;
        pulse_resume();
        check("R13 kept while busy", overuse, 1);
        wait_idle();
        check("R10 final done", done_cnt - d0, 1);
        check("R10 final sector", start_log[(start_cnt - 1) % 64], 6);
        check("R13 cleared", overuse, 0);
        check("R6 end pending", int'(pending), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule